// File: doc/BRIEF.md
# Virtual Channel DRAM Model

This block is a synthesizable behavioural model of a two-bank DRAM with a channel-buffer front end. Each bank has a storage array and one sense-amplifier row register. Next to the banks sits a small file of SRAM channel buffers, and each buffer holds one quarter of a row (a segment). Byte reads and byte writes address only the channel buffers, so they work whatever state the banks are in. Two commands move whole segments between a bank and a channel. Prefetch copies a segment of an open bank's sense row into a channel. Restore arms a precharged bank, and the next activate to that bank then writes the channel's segment into the row it opens.

Row count, segment size in bytes and channel count are parameters, so the array can be simulated small. One extra channel, numbered `NUM_CH`, is the dummy channel: it can be written, prefetched into and restored from, but it cannot be read. Any command that breaks a legality rule raises a one-cycle error pulse and changes no storage.

Top module: `vc_dram_model`

## Requirements
- R1: During and after reset, `rvalid_o` and `err_o` are low, both banks are precharged, no restore is armed, and every array byte and channel byte reads as zero.
- R2: Command codes on `cmd_i` are: 0 no-op, 1 activate, 2 precharge, 3 prefetch, 4 restore, 5 read, 6 write. Code 7, or a channel number above `NUM_CH` on prefetch, restore or write, makes `err_o` high for one cycle, in the cycle after the command, and changes nothing.
- R3: A write stores `wdata_i` into byte `col_i` of channel `chan_i`, for any channel 0..`NUM_CH` (including the dummy), whatever state the banks are in.
- R4: A read of channel 0..`NUM_CH`-1 sets `rvalid_o` high in the cycle after the command, with `rdata_o` equal to byte `col_i` of that channel, whatever state the banks are in.
- R5: A read of the dummy channel (`NUM_CH`) or of any higher number gives `err_o` high and `rvalid_o` low in the next cycle.
- R6: A prefetch to an open bank copies bytes `seg_i`*SEG_BYTES .. `seg_i`*SEG_BYTES+SEG_BYTES-1 of that bank's sense row into channel `chan_i`. A prefetch to a precharged bank flags an error and leaves the channel unchanged.
- R7: A restore to a precharged bank arms that bank with `seg_i` and `chan_i`. A restore to an open bank flags an error and arms nothing.
- R8: An activate to a precharged bank opens row `row_i`. If a restore is armed, the armed segment of that row is first replaced by the armed channel's contents as they are at the time of the activate, the result is written to the array, and the arming is cleared. An activate to an open bank flags an error and changes nothing.
- R9: A precharge closes the bank. A precharge to a bank that is already precharged is legal and has no effect.
- R10: A second restore to a bank that is already armed replaces the earlier one. Only the later segment and channel are committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_i | input | 3 | Command code (see R2) |
| bank_i | input | 1 | Bank select |
| row_i | input | $clog2(ROWS) | Row for activate |
| seg_i | input | 2 | Segment within a row |
| chan_i | input | $clog2(NUM_CH+1) | Channel number; `NUM_CH` is the dummy |
| col_i | input | $clog2(SEG_BYTES) | Byte within a segment |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Read byte |
| rvalid_o | output | 1 | Read byte valid |
| err_o | output | 1 | Illegal command pulse |

## Verification
Every result of this block is due exactly one clock edge after the command: the read byte and its strobe, the error pulse, and any change to a channel or the array. Bank open state and arming also take effect at that edge, so a command in the next cycle already sees them. The bench drives one command on each falling edge and samples `err_o`, `rvalid_o` and `rdata_o` on the following falling edge, before it drives the next command. It brings out stored segments by prefetch followed by read.

// File: rtl/vc_dram_pkg.sv
package vc_dram_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_PRE = 3'd2,
    CMD_PFX = 3'd3,
    CMD_RST = 3'd4,
    CMD_RD  = 3'd5,
    CMD_WR  = 3'd6,
    CMD_BAD = 3'd7
  } vc_cmd_e;

  localparam int unsigned NUM_BANKS    = 2;
  localparam int unsigned SEGS_PER_ROW = 4;
endpackage

// File: rtl/vc_cmd_decode.sv
module vc_cmd_decode
  import vc_dram_pkg::*;
#(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned CH_W   = 5
) (
  input  logic [2:0]           cmd_i,
  input  logic                 bank_i,
  input  logic [CH_W-1:0]      chan_i,
  input  logic [NUM_BANKS-1:0] bank_open_i,
  output logic [NUM_BANKS-1:0] act_o,
  output logic [NUM_BANKS-1:0] pre_o,
  output logic [NUM_BANKS-1:0] rst_o,
  output logic                 pfx_o,
  output logic                 rd_o,
  output logic                 wr_o,
  output logic                 err_o
);
  logic chan_ok, chan_rd, is_open;

  always_comb begin
    chan_ok = ({1'b0, chan_i} <= (CH_W+1)'(NUM_CH));
    chan_rd = ({1'b0, chan_i} <  (CH_W+1)'(NUM_CH));
    is_open = bank_open_i[bank_i];
    act_o = '0;
    pre_o = '0;
    rst_o = '0;
    pfx_o = 1'b0;
    rd_o  = 1'b0;
    wr_o  = 1'b0;
    err_o = 1'b0;
    case (vc_cmd_e'(cmd_i))
      CMD_NOP: ;
      CMD_ACT: if (is_open) err_o = 1'b1; else act_o[bank_i] = 1'b1;
      CMD_PRE: pre_o[bank_i] = 1'b1;
      CMD_PFX: if (!is_open || !chan_ok) err_o = 1'b1; else pfx_o = 1'b1;
      CMD_RST: if (is_open || !chan_ok) err_o = 1'b1; else rst_o[bank_i] = 1'b1;
      CMD_RD:  if (!chan_rd) err_o = 1'b1; else rd_o = 1'b1;
      CMD_WR:  if (!chan_ok) err_o = 1'b1; else wr_o = 1'b1;
      default: err_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/vc_chan_buf.sv
module vc_chan_buf
  import vc_dram_pkg::*;
#(
  parameter int unsigned NUM_CH    = 16,
  parameter int unsigned SEG_BYTES = 8,
  parameter int unsigned CH_W      = 5,
  parameter int unsigned COL_W     = 3,
  localparam int unsigned SEG_W    = SEG_BYTES * 8,
  localparam int unsigned NCH_TOT  = NUM_CH + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CH_W-1:0]  wr_chan_i,
  input  logic [COL_W-1:0] wr_col_i,
  input  logic [7:0]       wr_byte_i,
  input  logic             seg_wr_i,
  input  logic [CH_W-1:0]  seg_chan_i,
  input  logic [SEG_W-1:0] seg_data_i,
  input  logic [CH_W-1:0]  rd_chan_i,
  input  logic [COL_W-1:0] rd_col_i,
  output logic [7:0]       rd_byte_o,
  input  logic [CH_W-1:0]  cm_chan_i [NUM_BANKS],
  output logic [SEG_W-1:0] cm_data_o [NUM_BANKS]
);
  logic [SEG_W-1:0] buf_q [NCH_TOT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < NCH_TOT; c++) buf_q[c] <= '0;
    end else if (wr_i) begin
      buf_q[wr_chan_i][{wr_col_i, 3'b000} +: 8] <= wr_byte_i;
    end else if (seg_wr_i) begin
      buf_q[seg_chan_i] <= seg_data_i;
    end
  end

  always_comb begin
    rd_byte_o = '0;
    if (32'(rd_chan_i) < NCH_TOT) rd_byte_o = buf_q[rd_chan_i][{rd_col_i, 3'b000} +: 8];
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cm
    assign cm_data_o[b] = (32'(cm_chan_i[b]) < NCH_TOT) ? buf_q[cm_chan_i[b]] : '0;
  end
endmodule

// File: rtl/vc_bank.sv
module vc_bank
  import vc_dram_pkg::*;
#(
  parameter int unsigned ROWS      = 16,
  parameter int unsigned SEG_BYTES = 8,
  parameter int unsigned ROW_AW    = 4,
  parameter int unsigned CH_W      = 5,
  localparam int unsigned SEG_W    = SEG_BYTES * 8,
  localparam int unsigned ROW_W    = SEG_W * SEGS_PER_ROW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_i,
  input  logic              pre_i,
  input  logic              rst_i,
  input  logic [ROW_AW-1:0] row_i,
  input  logic [1:0]        seg_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic [SEG_W-1:0]  cm_data_i,
  output logic              open_o,
  output logic [CH_W-1:0]   pend_chan_o,
  output logic [SEG_W-1:0]  sense_seg_o
);
  logic [ROW_W-1:0] mem_q [ROWS];
  logic [ROW_W-1:0] sense_q, commit_row;
  logic             open_q, pend_q;
  logic [1:0]       pend_seg_q;
  logic [CH_W-1:0]  pend_chan_q;

  // merge of armed segment into the row being opened
  always_comb begin
    commit_row = mem_q[row_i];
    if (pend_q) commit_row[pend_seg_q*SEG_W +: SEG_W] = cm_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q      <= 1'b0;
      pend_q      <= 1'b0;
      pend_seg_q  <= '0;
      pend_chan_q <= '0;
      sense_q     <= '0;
      for (int r = 0; r < ROWS; r++) mem_q[r] <= '0;
    end else if (act_i) begin
      mem_q[row_i] <= commit_row;
      sense_q      <= commit_row;
      open_q       <= 1'b1;
      pend_q       <= 1'b0;
    end else if (pre_i) begin
      open_q <= 1'b0;
    end else if (rst_i) begin
      pend_q      <= 1'b1;
      pend_seg_q  <= seg_i;
      pend_chan_q <= chan_i;
    end
  end

  assign open_o      = open_q;
  assign pend_chan_o = pend_chan_q;
  assign sense_seg_o = sense_q[seg_i*SEG_W +: SEG_W];
endmodule

// File: rtl/vc_dram_model.sv
module vc_dram_model
  import vc_dram_pkg::*;
#(
  parameter int unsigned ROWS      = 16,
  parameter int unsigned SEG_BYTES = 8,
  parameter int unsigned NUM_CH    = 16,
  localparam int unsigned ROW_AW   = $clog2(ROWS),
  localparam int unsigned COL_W    = $clog2(SEG_BYTES),
  localparam int unsigned CH_W     = $clog2(NUM_CH + 1),
  localparam int unsigned SEG_W    = SEG_BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        cmd_i,
  input  logic              bank_i,
  input  logic [ROW_AW-1:0] row_i,
  input  logic [1:0]        seg_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              rvalid_o,
  output logic              err_o
);
  logic [NUM_BANKS-1:0] act_v, pre_v, rst_v, bank_open;
  logic                 pfx_v, rd_v, wr_v, err_v;
  logic [SEG_W-1:0]     sense_seg [NUM_BANKS];
  logic [SEG_W-1:0]     cm_data   [NUM_BANKS];
  logic [CH_W-1:0]      pend_chan [NUM_BANKS];
  logic [7:0]           rd_byte;

  vc_cmd_decode #(.NUM_CH(NUM_CH), .CH_W(CH_W)) dec_i (
    .cmd_i       (cmd_i),
    .bank_i      (bank_i),
    .chan_i      (chan_i),
    .bank_open_i (bank_open),
    .act_o       (act_v),
    .pre_o       (pre_v),
    .rst_o       (rst_v),
    .pfx_o       (pfx_v),
    .rd_o        (rd_v),
    .wr_o        (wr_v),
    .err_o       (err_v)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    vc_bank #(
      .ROWS(ROWS), .SEG_BYTES(SEG_BYTES), .ROW_AW(ROW_AW), .CH_W(CH_W)
    ) bank_i_u (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .act_i       (act_v[b]),
      .pre_i       (pre_v[b]),
      .rst_i       (rst_v[b]),
      .row_i       (row_i),
      .seg_i       (seg_i),
      .chan_i      (chan_i),
      .cm_data_i   (cm_data[b]),
      .open_o      (bank_open[b]),
      .pend_chan_o (pend_chan[b]),
      .sense_seg_o (sense_seg[b])
    );
  end

  vc_chan_buf #(
    .NUM_CH(NUM_CH), .SEG_BYTES(SEG_BYTES), .CH_W(CH_W), .COL_W(COL_W)
  ) chan_u (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_v),
    .wr_chan_i  (chan_i),
    .wr_col_i   (col_i),
    .wr_byte_i  (wdata_i),
    .seg_wr_i   (pfx_v),
    .seg_chan_i (chan_i),
    .seg_data_i (sense_seg[bank_i]),
    .rd_chan_i  (chan_i),
    .rd_col_i   (col_i),
    .rd_byte_o  (rd_byte),
    .cm_chan_i  (pend_chan),
    .cm_data_o  (cm_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      rvalid_o <= rd_v;
      err_o    <= err_v;
      if (rd_v) rdata_o <= rd_byte;
    end
  end
endmodule

// File: rtl/vc_dram_model_chk.sv
module vc_dram_model_chk #(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned CH_W   = 5,
  parameter int unsigned COL_W  = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       cmd_i,
  input logic             bank_i,
  input logic [CH_W-1:0]  chan_i,
  input logic [COL_W-1:0] col_i,
  input logic [7:0]       wdata_i,
  input logic [7:0]       rdata_o,
  input logic             rvalid_o,
  input logic             err_o,
  input logic [1:0]       bank_open
);
  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!rvalid_o && !err_o && bank_open == 2'b00));

  assert_bad_code_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == 3'd7 |=> err_o && !rvalid_o);

  assert_wr_then_rd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cmd_i) == 3'd6 && cmd_i == 3'd5 && $past(chan_i) == chan_i &&
     $past(col_i) == col_i && 32'(chan_i) < NUM_CH) |=> rdata_o == $past(wdata_i, 2));

  assert_rd_valid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd5 && 32'(chan_i) < NUM_CH) |=> rvalid_o && !err_o);

  assert_rd_dummy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd5 && 32'(chan_i) >= NUM_CH) |=> err_o && !rvalid_o);

  assert_pfx_closed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd3 && !bank_open[bank_i]) |=> err_o);

  assert_rst_open_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd4 && bank_open[bank_i]) |=> err_o);

  assert_act_opens_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd1 && !bank_open[bank_i]) |=> bank_open[$past(bank_i)] && !err_o);

  assert_pre_closes_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == 3'd2 |=> !bank_open[$past(bank_i)] && !err_o);

  assert_one_result_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rvalid_o && err_o));
endmodule

bind vc_dram_model vc_dram_model_chk #(
  .NUM_CH(NUM_CH), .CH_W(CH_W), .COL_W(COL_W)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cmd_i     (cmd_i),
  .bank_i    (bank_i),
  .chan_i    (chan_i),
  .col_i     (col_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .rvalid_o  (rvalid_o),
  .err_o     (err_o),
  .bank_open (bank_open)
);

// File: tb/vc_dram_model_tb_top.sv
module vc_dram_model_tb_top;
  localparam int ROWS      = 16;
  localparam int SEG_BYTES = 8;
  localparam int NUM_CH    = 16;
  localparam int ROW_AW    = 4;
  localparam int COL_W     = 3;
  localparam int CH_W      = 5;
  localparam int ROW_BYTES = SEG_BYTES * 4;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [2:0]        cmd_i = '0;
  logic              bank_i = '0;
  logic [ROW_AW-1:0] row_i = '0;
  logic [1:0]        seg_i = '0;
  logic [CH_W-1:0]   chan_i = '0;
  logic [COL_W-1:0]  col_i = '0;
  logic [7:0]        wdata_i = '0;
  logic [7:0]        rdata_o;
  logic              rvalid_o, err_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk_i = ~clk_i;

  vc_dram_model #(.ROWS(ROWS), .SEG_BYTES(SEG_BYTES), .NUM_CH(NUM_CH)) dut_i (
    .clk_i, .rst_ni, .cmd_i, .bank_i, .row_i, .seg_i, .chan_i, .col_i,
    .wdata_i, .rdata_o, .rvalid_o, .err_o
  );

  // reference state
  logic [7:0] ref_mem [2][ROWS][ROW_BYTES];
  logic [7:0] ref_ch  [NUM_CH+1][SEG_BYTES];
  bit ref_open [2];
  bit ref_pend [2];
  int ref_orow [2];
  int ref_pseg [2];
  int ref_pch  [2];

  typedef struct packed {
    logic [2:0] cmd; logic bank; logic [3:0] row; logic [1:0] seg;
    logic [4:0] chan; logic [2:0] col; logic [7:0] wd;
    logic x_err; logic x_rv; logic [7:0] x_rd;
  } vec_t;

  localparam logic [35:0] VEC [19] = '{
    {3'd6,1'b0,4'd0,2'd0,5'd3, 3'd2,8'hAB,1'b0,1'b0,8'h00}, // wr ch3
    {3'd5,1'b0,4'd0,2'd0,5'd3, 3'd2,8'h00,1'b0,1'b1,8'hAB}, // rd ch3
    {3'd3,1'b0,4'd0,2'd0,5'd1, 3'd0,8'h00,1'b1,1'b0,8'h00}, // pfx closed
    {3'd4,1'b0,4'd0,2'd1,5'd3, 3'd0,8'h00,1'b0,1'b0,8'h00}, // rst arm
    {3'd1,1'b0,4'd5,2'd0,5'd0, 3'd0,8'h00,1'b0,1'b0,8'h00}, // act commit
    {3'd1,1'b0,4'd6,2'd0,5'd0, 3'd0,8'h00,1'b1,1'b0,8'h00}, // act open
    {3'd3,1'b0,4'd0,2'd1,5'd7, 3'd0,8'h00,1'b0,1'b0,8'h00}, // pfx seg1
    {3'd5,1'b0,4'd0,2'd0,5'd7, 3'd2,8'h00,1'b0,1'b1,8'hAB},
    {3'd5,1'b0,4'd0,2'd0,5'd7, 3'd0,8'h00,1'b0,1'b1,8'h00},
    {3'd5,1'b0,4'd0,2'd0,5'd16,3'd0,8'h00,1'b1,1'b0,8'h00}, // rd dummy
    {3'd6,1'b0,4'd0,2'd0,5'd16,3'd1,8'h5A,1'b0,1'b0,8'h00}, // wr dummy
    {3'd4,1'b0,4'd0,2'd0,5'd2, 3'd0,8'h00,1'b1,1'b0,8'h00}, // rst open
    {3'd2,1'b0,4'd0,2'd0,5'd0, 3'd0,8'h00,1'b0,1'b0,8'h00},
    {3'd4,1'b1,4'd0,2'd3,5'd16,3'd0,8'h00,1'b0,1'b0,8'h00}, // rst dummy
    {3'd1,1'b1,4'd2,2'd0,5'd0, 3'd0,8'h00,1'b0,1'b0,8'h00},
    {3'd3,1'b1,4'd0,2'd3,5'd0, 3'd0,8'h00,1'b0,1'b0,8'h00},
    {3'd5,1'b0,4'd0,2'd0,5'd0, 3'd1,8'h00,1'b0,1'b1,8'h5A},
    {3'd7,1'b0,4'd0,2'd0,5'd0, 3'd0,8'h00,1'b1,1'b0,8'h00}, // bad code
    {3'd6,1'b0,4'd0,2'd0,5'd20,3'd0,8'h11,1'b1,1'b0,8'h00}  // wr chan out of range
  };

  function automatic string req_of(int c, bit e_err);
    case (c)
      1: return "R8";
      2: return "R9";
      3: return "R6";
      4: return "R7";
      5: return e_err ? "R5" : "R4";
      6: return e_err ? "R2" : "R3";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(string rq, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic ref_step(int c, int b, int r, int s, int ch, int col, int wd,
                          output bit e_err, output bit e_rv, output int e_rd);
    e_err = 0; e_rv = 0; e_rd = 0;
    case (c)
      1: if (ref_open[b]) e_err = 1;
         else begin
           if (ref_pend[b])
             for (int k = 0; k < SEG_BYTES; k++)
               ref_mem[b][r][ref_pseg[b]*SEG_BYTES+k] = ref_ch[ref_pch[b]][k];
           ref_open[b] = 1; ref_orow[b] = r; ref_pend[b] = 0;
         end
      2: ref_open[b] = 0;
      3: if (!ref_open[b] || ch > NUM_CH) e_err = 1;
         else for (int k = 0; k < SEG_BYTES; k++)
           ref_ch[ch][k] = ref_mem[b][ref_orow[b]][s*SEG_BYTES+k];
      4: if (ref_open[b] || ch > NUM_CH) e_err = 1;
         else begin ref_pend[b] = 1; ref_pseg[b] = s; ref_pch[b] = ch; end
      5: if (ch >= NUM_CH) e_err = 1;
         else begin e_rv = 1; e_rd = ref_ch[ch][col]; end
      6: if (ch > NUM_CH) e_err = 1; else ref_ch[ch][col] = 8'(wd);
      7: e_err = 1;
      default: ;
    endcase
  endtask

  task automatic step(int c, int b, int r, int s, int ch, int col, int wd,
                      string tag, bit has_x, bit x_err, bit x_rv, int x_rd);
    bit e_err, e_rv; int e_rd; string rq;
    ref_step(c, b, r, s, ch, col, wd, e_err, e_rv, e_rd);
    cmd_i = 3'(c); bank_i = 1'(b); row_i = ROW_AW'(r); seg_i = 2'(s);
    chan_i = CH_W'(ch); col_i = COL_W'(col); wdata_i = 8'(wd);
    @(posedge clk_i); @(negedge clk_i);
    rq = (tag != "") ? tag : req_of(c, e_err);
    chk(rq, "err", err_o, e_err);
    chk(rq, "rvalid", rvalid_o, e_rv);
    if (e_rv) chk(rq, "rdata", rdata_o, e_rd);
    if (has_x) begin
      chk(rq, "err vec", err_o, x_err);
      chk(rq, "rvalid vec", rvalid_o, x_rv);
      if (x_rv) chk(rq, "rdata vec", rdata_o, x_rd);
    end
    cmd_i = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 2; b++) begin
      ref_open[b] = 0; ref_pend[b] = 0; ref_orow[b] = 0; ref_pseg[b] = 0; ref_pch[b] = 0;
      for (int r = 0; r < ROWS; r++)
        for (int k = 0; k < ROW_BYTES; k++) ref_mem[b][r][k] = '0;
    end
    for (int c = 0; c <= NUM_CH; c++)
      for (int k = 0; k < SEG_BYTES; k++) ref_ch[c][k] = '0;

    repeat (3) @(negedge clk_i);
    chk("R1", "rvalid in reset", rvalid_o, 0);
    chk("R1", "err in reset", err_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "rvalid after reset", rvalid_o, 0);
    chk("R1", "err after reset", err_o, 0);
    step(5, 0, 0, 0, 0, 0, 0, "R1", 1, 0, 1, 0);   // channel zero
    step(3, 0, 0, 0, 1, 0, 0, "R1", 1, 1, 0, 0);   // bank precharged
    step(1, 1, 4, 0, 0, 0, 0, "R1", 1, 0, 0, 0);
    step(3, 1, 0, 2, 1, 0, 0, "R1", 1, 0, 0, 0);
    step(5, 0, 0, 0, 1, 5, 0, "R1", 1, 0, 1, 0);   // array zero
    step(2, 1, 0, 0, 0, 0, 0, "R9", 1, 0, 0, 0);

    for (int i = 0; i < 19; i++) begin
      vec_t v = vec_t'(VEC[i]);
      step(int'(v.cmd), int'(v.bank), int'(v.row), int'(v.seg), int'(v.chan),
           int'(v.col), int'(v.wd), "", 1, v.x_err, v.x_rv, int'(v.x_rd));
    end

    // R9: precharge of a precharged bank
    step(2, 0, 0, 0, 0, 0, 0, "R9", 1, 0, 0, 0);
    step(2, 0, 0, 0, 0, 0, 0, "R9", 1, 0, 0, 0);
    // R10: later restore wins
    step(2, 1, 0, 0, 0, 0, 0, "R10", 1, 0, 0, 0);
    step(6, 0, 0, 0, 4, 0, 8'h11, "R10", 1, 0, 0, 0);
    step(6, 0, 0, 0, 5, 0, 8'h22, "R10", 1, 0, 0, 0);
    step(4, 1, 0, 0, 4, 0, 0, "R10", 1, 0, 0, 0);
    step(4, 1, 0, 2, 5, 0, 0, "R10", 1, 0, 0, 0);
    step(1, 1, 9, 0, 0, 0, 0, "R10", 1, 0, 0, 0);
    step(3, 1, 0, 0, 6, 0, 0, "R10", 1, 0, 0, 0);
    step(5, 0, 0, 0, 6, 0, 0, "R10", 1, 0, 1, 0);
    step(3, 1, 0, 2, 6, 0, 0, "R10", 1, 0, 0, 0);
    step(5, 0, 0, 0, 6, 0, 0, "R10", 1, 0, 1, 8'h22);
    // R8: channel content at activate time is committed
    step(2, 1, 0, 0, 0, 0, 0, "R8", 1, 0, 0, 0);
    step(4, 1, 0, 1, 8, 0, 0, "R8", 1, 0, 0, 0);
    step(6, 0, 0, 0, 8, 7, 8'h77, "R8", 1, 0, 0, 0);
    step(1, 1, 3, 0, 0, 0, 0, "R8", 1, 0, 0, 0);
    step(3, 1, 0, 1, 9, 0, 0, "R8", 1, 0, 0, 0);
    step(5, 0, 0, 0, 9, 7, 0, "R8", 1, 0, 1, 8'h77);

    for (int i = 0; i < 3000; i++) begin
      int c, ch, r;
      c  = $urandom_range(7, 0);
      ch = ($urandom_range(3, 0) == 0) ? $urandom_range(19, 0) : $urandom_range(3, 0);
      r  = ($urandom_range(3, 0) == 0) ? $urandom_range(ROWS-1, 0) : $urandom_range(2, 0);
      step(c, $urandom_range(1, 0), r, $urandom_range(3, 0), ch,
           $urandom_range(SEG_BYTES-1, 0), $urandom_range(255, 0), "", 0, 0, 0, 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule